// File: doc/BRIEF.md
# Three-wire tuner control port

This block is the slave end of a three-wire serial link through which a host microprocessor programs a tuner and reads back its status. The host drives a chip-select line, a serial clock and a serial data input. The block answers on a serial data output that it can release. The host first clocks two address bits while chip-select is low. It then raises chip-select and clocks a 21-bit frame. The address picks one of four modes: a test-register write, a status read, and two configuration writes whose destination register also depends on the low test bits.

All three host lines are asynchronous to the system clock. They pass through two-flop synchronisers, and serial clock edges are detected on the synchronised copy. A write commits only on the falling edge of chip-select, and only if exactly 21 bits were clocked. A status read captures the status word when chip-select rises and shifts it out most significant bit first. A completed read also clears the IF-count-start flag and pulses a restart to the IF counter. A configuration write that takes the output-select field out of its PLL-stop code pulses a reset to the PLL reference and comparison counters. Between frames the output pin serves as an open-drain status line, either for lock or for IF-count-done, as set by a two-bit field.

Top module: `tuner_serial_ctrl`

## Requirements
- R1: After reset, `tune_a_o`, `tune_b_o` and `test_o` are all zero, `sif_oe_o` is low, and both pulse outputs are low.
- R2: While chip-select is low, each serial clock rising edge shifts `sif_dat_i` into a two-bit address, LSB first, so the last two edges before chip-select rises set the mode. The codes are 0 test write, 1 status read, 2 configuration write A, and 3 configuration write B.
- R3: While chip-select is high, each serial clock rising edge shifts one data bit in, bit 20 first. When chip-select falls after exactly 21 edges in mode 0, the frame is loaded into `test_o`.
- R4: In mode 2 a complete frame loads `tune_a_o` when `test_o[1:0]` is 00, and loads `tune_b_o` otherwise. In mode 3 a complete frame always loads `tune_b_o`.
- R5: In mode 1, `stat_word_i` is captured when chip-select rises. While chip-select stays high, `sif_oe_o` is high and `sif_dat_o` shows bit 20. Each serial clock rising edge then moves the output to the next lower bit, and once all 21 bits are out the pin shows 0.
- R6: When chip-select falls after exactly 21 edges in mode 1, bit 20 of `tune_a_o` (the IF-count-start flag) clears and `ifc_restart_o` is high for exactly one clock.
- R7: When a mode 2 frame is loaded into `tune_a_o` while bits 18:17 held 11 (PLL stop) and the new bits 18:17 are not 11, `ctr_reset_o` is high for exactly one clock. No other write pulses it.
- R8: Outside a frame, `tune_b_o[20:19]` controls the output. With 00 or 01 the pin is released. With 10 it is driven low whenever `pll_lock_i` is high. With 11 it is driven low whenever `ifc_done_i` is high.
- R9: During a frame in mode 0, 2 or 3, `sif_oe_o` stays low whatever the value of `tune_b_o[20:19]`, `pll_lock_i` and `ifc_done_i`.
- R10: A frame that ends with a bit count other than 21 (shorter or longer) is discarded: no register changes and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sif_sel_i | input | 1 | Host chip-select, high during a frame |
| sif_clk_i | input | 1 | Host serial clock, sampled on rising edges |
| sif_dat_i | input | 1 | Host serial data into the block |
| sif_dat_o | output | 1 | Serial data or status level out to the host |
| sif_oe_o | output | 1 | Drive enable for `sif_dat_o`; low means released |
| stat_word_i | input | FRAME_W | Status word returned by a mode 1 read |
| pll_lock_i | input | 1 | PLL lock indication, synchronous to `clk` |
| ifc_done_i | input | 1 | IF counting finished, synchronous to `clk` |
| tune_a_o | output | FRAME_W | Configuration register A |
| tune_b_o | output | FRAME_W | Configuration register B |
| test_o | output | FRAME_W | Test register |
| ctr_reset_o | output | 1 | One-clock reset to the PLL reference and comparison counters |
| ifc_restart_o | output | 1 | One-clock restart to the IF counter |

## Verification
A level change on a host pin reaches the registers on the third rising clock edge after it: two synchroniser flops, then the edge-detect stage. Register loads, pulses and the drive of the output pin therefore all become visible after that edge. The lock and IF-done inputs are synchronous and reach the output pin within the same cycle. The bench holds every host pin level for four clock periods and compares the outputs with its reference model only from the fourth falling edge after a change. Pulse outputs are sampled on every falling edge, so each pulse is counted once and its width is checked.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // Mode codes carried by the two address bits (R2)
  typedef enum logic [1:0] {
    MODE_TEST = 2'd0,
    MODE_READ = 2'd1,
    MODE_WRA  = 2'd2,
    MODE_WRB  = 2'd3
  } mode_e;

  // Idle output control codes held in register B (R8)
  typedef enum logic [1:0] {
    DOC_REL0  = 2'd0,
    DOC_REL1  = 2'd1,
    DOC_LOCK  = 2'd2,
    DOC_IFEND = 2'd3
  } doc_e;

  // Field positions that other logic decodes
  localparam int unsigned SEL_HI   = 1;   // test register: write-A steering
  localparam int unsigned SEL_LO   = 0;
  localparam int unsigned OS_HI    = 18;  // register A: output select
  localparam int unsigned OS_LO    = 17;
  localparam int unsigned IFCS_BIT = 20;  // register A: IF count start flag
  localparam int unsigned DOC_HI   = 20;  // register B: idle output control
  localparam int unsigned DOC_LO   = 19;

  localparam logic [1:0] OS_STOP = 2'b11;

endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_nx;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_nx = async_i;
    end else begin : g_multi
      always_comb chain_nx = {chain_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_nx;
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/tsc_frame.sv
// Frame engine: address capture while deselected (R2), data shift and bit
// count while selected (R3, R5), end-of-frame qualification (R10).
module tsc_frame
  import tsc_pkg::*;
#(
  parameter int unsigned FRAME_W = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_s,
  input  logic               sck_s,
  input  logic               dat_s,
  input  logic [FRAME_W-1:0] load_word,
  output mode_e              mode_o,
  output logic               active_o,
  output logic [FRAME_W-1:0] shift_o,
  output logic               done_o
);

  localparam int unsigned      CNT_W    = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic               sel_d_q;
  logic               sck_d_q;
  logic [1:0]         addr_q,  addr_nx;
  logic [FRAME_W-1:0] shift_q, shift_nx;
  logic [CNT_W-1:0]   cnt_q,   cnt_nx;
  logic               sck_rise, sel_rise, sel_fall, is_read;
  logic               addr_en, shift_en;

  always_comb begin
    sck_rise = sck_s & ~sck_d_q;
    sel_rise = sel_s & ~sel_d_q;
    sel_fall = ~sel_s & sel_d_q;
    is_read  = (mode_e'(addr_q) == MODE_READ);
    addr_en  = sck_rise & ~sel_s;
    shift_en = sel_rise | (sck_rise & sel_s);

    addr_nx  = addr_q;
    shift_nx = shift_q;
    cnt_nx   = cnt_q;

    if (addr_en) begin
      addr_nx = {dat_s, addr_q[1]};
    end

    if (sel_rise) begin
      shift_nx = is_read ? load_word : '0;
      cnt_nx   = '0;
    end else if (shift_en) begin
      shift_nx = {shift_q[FRAME_W-2:0], (is_read ? 1'b0 : dat_s)};
      if (cnt_q != CNT_SAT) begin
        cnt_nx = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_d_q <= 1'b0;
      sck_d_q <= 1'b0;
      addr_q  <= '0;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      sel_d_q <= sel_s;
      sck_d_q <= sck_s;
      if (addr_en) begin
        addr_q <= addr_nx;
      end
      if (shift_en) begin
        shift_q <= shift_nx;
        cnt_q   <= cnt_nx;
      end
    end
  end

  assign mode_o   = mode_e'(addr_q);
  assign active_o = sel_d_q;
  assign shift_o  = shift_q;
  assign done_o   = sel_fall & (cnt_q == CNT_FULL);

endmodule

// File: rtl/tsc_regs.sv
// Register bank: commit of complete frames (R3, R4), read completion (R6),
// counter reset on leaving PLL stop (R7).
module tsc_regs
  import tsc_pkg::*;
#(
  parameter int unsigned FRAME_W = 21
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               done_i,
  input  mode_e              mode_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [FRAME_W-1:0] reg_a_o,
  output logic [FRAME_W-1:0] reg_b_o,
  output logic [FRAME_W-1:0] reg_t_o,
  output logic               ctr_rst_o,
  output logic               ifc_rst_o
);

  logic [FRAME_W-1:0] a_q, a_nx;
  logic [FRAME_W-1:0] b_q, b_nx;
  logic [FRAME_W-1:0] t_q, t_nx;
  logic               ctr_q, ctr_nx;
  logic               ifr_q, ifr_nx;
  logic               steer_b;
  logic               leave_stop;

  always_comb begin
    a_nx       = a_q;
    b_nx       = b_q;
    t_nx       = t_q;
    ctr_nx     = 1'b0;
    ifr_nx     = 1'b0;
    steer_b    = (t_q[SEL_HI:SEL_LO] != 2'b00);
    leave_stop = (a_q[OS_HI:OS_LO] == OS_STOP) && (word_i[OS_HI:OS_LO] != OS_STOP);

    if (done_i) begin
      case (mode_i)
        MODE_TEST: t_nx = word_i;
        MODE_READ: begin
          a_nx[IFCS_BIT] = 1'b0;
          ifr_nx         = 1'b1;
        end
        MODE_WRA: begin
          if (steer_b) begin
            b_nx = word_i;
          end else begin
            a_nx   = word_i;
            ctr_nx = leave_stop;
          end
        end
        default: b_nx = word_i;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      t_q   <= '0;
      ctr_q <= 1'b0;
      ifr_q <= 1'b0;
    end else begin
      if (done_i) begin
        a_q <= a_nx;
        b_q <= b_nx;
        t_q <= t_nx;
      end
      ctr_q <= ctr_nx;
      ifr_q <= ifr_nx;
    end
  end

  assign reg_a_o   = a_q;
  assign reg_b_o   = b_q;
  assign reg_t_o   = t_q;
  assign ctr_rst_o = ctr_q;
  assign ifc_rst_o = ifr_q;

endmodule

// File: rtl/tsc_dout.sv
// Output pin steering: read data in a frame (R5), released in write frames
// (R9), open-drain status between frames (R8).
module tsc_dout
  import tsc_pkg::*;
(
  input  logic       active_i,
  input  mode_e      mode_i,
  input  logic       msb_i,
  input  logic [1:0] doc_i,
  input  logic       lock_i,
  input  logic       ifdone_i,
  output logic       dat_o,
  output logic       oe_o
);

  always_comb begin
    dat_o = 1'b0;
    oe_o  = 1'b0;
    if (active_i) begin
      if (mode_i == MODE_READ) begin
        oe_o  = 1'b1;
        dat_o = msb_i;
      end
    end else begin
      case (doc_e'(doc_i))
        DOC_LOCK:  oe_o = lock_i;
        DOC_IFEND: oe_o = ifdone_i;
        default:   oe_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/tuner_serial_ctrl.sv
module tuner_serial_ctrl
  import tsc_pkg::*;
#(
  parameter int unsigned FRAME_W     = 21,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sif_sel_i,
  input  logic               sif_clk_i,
  input  logic               sif_dat_i,
  output logic               sif_dat_o,
  output logic               sif_oe_o,
  input  logic [FRAME_W-1:0] stat_word_i,
  input  logic               pll_lock_i,
  input  logic               ifc_done_i,
  output logic [FRAME_W-1:0] tune_a_o,
  output logic [FRAME_W-1:0] tune_b_o,
  output logic [FRAME_W-1:0] test_o,
  output logic               ctr_reset_o,
  output logic               ifc_restart_o
);

  localparam int unsigned PIN_W = 3;

  logic                 rst_n_s;
  logic [PIN_W-1:0]     pins_s;
  mode_e                xfer_mode;
  logic                 xfer_act;
  logic [FRAME_W-1:0]   xfer_word;
  logic                 xfer_done;

  // Reset: asserted asynchronously, released on the clock (R1)
  tsc_sync #(.WIDTH(1), .STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (1'b1),
    .sync_o  (rst_n_s)
  );

  tsc_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .async_i ({sif_sel_i, sif_clk_i, sif_dat_i}),
    .sync_o  (pins_s)
  );

  tsc_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sel_s     (pins_s[2]),
    .sck_s     (pins_s[1]),
    .dat_s     (pins_s[0]),
    .load_word (stat_word_i),
    .mode_o    (xfer_mode),
    .active_o  (xfer_act),
    .shift_o   (xfer_word),
    .done_o    (xfer_done)
  );

  tsc_regs #(.FRAME_W(FRAME_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .done_i    (xfer_done),
    .mode_i    (xfer_mode),
    .word_i    (xfer_word),
    .reg_a_o   (tune_a_o),
    .reg_b_o   (tune_b_o),
    .reg_t_o   (test_o),
    .ctr_rst_o (ctr_reset_o),
    .ifc_rst_o (ifc_restart_o)
  );

  tsc_dout u_dout (
    .active_i (xfer_act),
    .mode_i   (xfer_mode),
    .msb_i    (xfer_word[FRAME_W-1]),
    .doc_i    (tune_b_o[DOC_HI:DOC_LO]),
    .lock_i   (pll_lock_i),
    .ifdone_i (ifc_done_i),
    .dat_o    (sif_dat_o),
    .oe_o     (sif_oe_o)
  );

endmodule

// File: rtl/tuner_serial_ctrl_chk.sv
module tuner_serial_ctrl_chk
  import tsc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_act,
  input logic       read_mode,
  input logic       oe,
  input logic       ctr_pulse,
  input logic       ifr_pulse,
  input logic [1:0] os_field,
  input logic       ifcs_flag,
  input logic       doc_hi
);

  assert_ctr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_pulse |=> !ctr_pulse);

  assert_ctr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_pulse |-> (($past(os_field) == OS_STOP) && (os_field != OS_STOP)));

  assert_ifr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ifr_pulse |=> !ifr_pulse);

  assert_ifcs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ifr_pulse |-> !ifcs_flag);

  assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_act && !doc_hi) |-> !oe);

  assert_write_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_act && !read_mode) |-> !oe);

endmodule

bind tuner_serial_ctrl tuner_serial_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xfer_act  (xfer_act),
  .read_mode (xfer_mode == tsc_pkg::MODE_READ),
  .oe        (sif_oe_o),
  .ctr_pulse (ctr_reset_o),
  .ifr_pulse (ifc_restart_o),
  .os_field  (tune_a_o[tsc_pkg::OS_HI:tsc_pkg::OS_LO]),
  .ifcs_flag (tune_a_o[tsc_pkg::IFCS_BIT]),
  .doc_hi    (tune_b_o[tsc_pkg::DOC_HI])
);

// File: tb/tuner_serial_ctrl_test.sv
module tuner_serial_ctrl_test;

  localparam int unsigned W = 21;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ce_pin = 1'b0;
  logic         cl_pin = 1'b0;
  logic         di_pin = 1'b0;
  logic [W-1:0] stat = '0;
  logic         lock = 1'b0;
  logic         ifd = 1'b0;
  logic         sif_dat_o, sif_oe_o, ctr_reset_o, ifc_restart_o;
  logic [W-1:0] tune_a_o, tune_b_o, test_o;

  always #4 clk = ~clk;

  tuner_serial_ctrl #(.FRAME_W(W)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .sif_sel_i     (ce_pin),
    .sif_clk_i     (cl_pin),
    .sif_dat_i     (di_pin),
    .sif_dat_o     (sif_dat_o),
    .sif_oe_o      (sif_oe_o),
    .stat_word_i   (stat),
    .pll_lock_i    (lock),
    .ifc_done_i    (ifd),
    .tune_a_o      (tune_a_o),
    .tune_b_o      (tune_b_o),
    .test_o        (test_o),
    .ctr_reset_o   (ctr_reset_o),
    .ifc_restart_o (ifc_restart_o)
  );

  int checks = 0;
  int errors = 0;
  int quiet = 0;
  bit live = 1'b0;
  string cur_req = "R1";

  // Behavioural reference state
  logic [W-1:0] m_a = '0, m_b = '0, m_t = '0, m_shift = '0;
  logic [1:0]   m_addr = 2'b00;
  logic         m_act = 1'b0;
  int           m_bits = 0;
  int           m_ctr = 0, m_ifr = 0, got_ctr = 0, got_ifr = 0;
  logic         prev_ctr = 1'b0, prev_ifr = 1'b0;

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic commit();
    case (m_addr)
      2'd0: m_t = m_shift;
      2'd1: begin m_a[20] = 1'b0; m_ifr++; end
      2'd2: begin
        if (m_t[1:0] == 2'b00) begin
          if (m_a[18:17] == 2'b11 && m_shift[18:17] != 2'b11) m_ctr++;
          m_a = m_shift;
        end else begin
          m_b = m_shift;
        end
      end
      default: m_b = m_shift;
    endcase
  endtask

  // Every host pin level is held four clock periods
  task automatic pins(input logic ce, input logic cl, input logic di);
    @(negedge clk);
    if (!ce_pin && ce) begin
      m_act = 1'b1; m_bits = 0;
      m_shift = (m_addr == 2'd1) ? stat : '0;
    end else if (ce_pin && !ce) begin
      m_act = 1'b0;
      if (m_bits == W) commit();
    end else if (!cl_pin && cl) begin
      if (ce) begin
        m_shift = {m_shift[W-2:0], (m_addr == 2'd1) ? 1'b0 : di};
        m_bits++;
      end else begin
        m_addr = {di, m_addr[1]};
      end
    end
    ce_pin = ce; cl_pin = cl; di_pin = di; quiet = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_io(input logic lk, input logic fd);
    @(negedge clk);
    lock = lk; ifd = fd; quiet = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(input string req, input int junk, input logic [1:0] addr,
                       input logic [W-1:0] data, input int nbits);
    cur_req = req;
    for (int j = 0; j < junk; j++) begin
      pins(1'b0, 1'b0, 1'b1); pins(1'b0, 1'b1, 1'b1);
    end
    pins(1'b0, 1'b0, addr[0]); pins(1'b0, 1'b1, addr[0]);
    pins(1'b0, 1'b0, addr[1]); pins(1'b0, 1'b1, addr[1]);
    pins(1'b0, 1'b0, 1'b0);
    pins(1'b1, 1'b0, 1'b0);
    if (addr == 2'd1) begin
      check("R5", sif_oe_o, 1, "read drive at start");
      check("R5", sif_dat_o, stat[W-1], "first read bit");
    end else begin
      check("R9", sif_oe_o, 0, "write frame release");
    end
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < W) ? data[W-1-i] : 1'b0;
      pins(1'b1, 1'b0, b);
      pins(1'b1, 1'b1, b);
      if (addr == 2'd1) begin
        if (i + 1 < W) check("R5", sif_dat_o, stat[W-2-i], "read bit");
        else           check("R5", sif_dat_o, 0, "read after last bit");
      end
    end
    pins(1'b1, 1'b0, 1'b0);
    pins(1'b0, 1'b0, 1'b0);
  endtask

  // Per-clock comparison against the reference model
  always @(negedge clk) begin
    logic e_oe;
    #1;
    quiet = quiet + 1;
    if (ctr_reset_o) begin
      got_ctr++;
      check("R7", prev_ctr, 0, "counter reset pulse width");
    end
    if (ifc_restart_o) begin
      got_ifr++;
      check("R6", prev_ifr, 0, "restart pulse width");
    end
    prev_ctr = ctr_reset_o;
    prev_ifr = ifc_restart_o;
    if (live && quiet >= 4) begin
      if (m_act) e_oe = (m_addr == 2'd1);
      else if (m_b[20:19] == 2'b10) e_oe = lock;
      else if (m_b[20:19] == 2'b11) e_oe = ifd;
      else e_oe = 1'b0;
      check(cur_req, tune_a_o, m_a, "model register A");
      check(cur_req, tune_b_o, m_b, "model register B");
      check(cur_req, test_o, m_t, "model test register");
      check(cur_req, sif_oe_o, e_oe, "model drive enable");
      if (e_oe && m_act) check(cur_req, sif_dat_o, m_shift[W-1], "model read bit");
      if (e_oe && !m_act) check(cur_req, sif_dat_o, 0, "model status level");
      check(cur_req, got_ctr, m_ctr, "model counter reset count");
      check(cur_req, got_ifr, m_ifr, "model restart count");
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1", tune_a_o, 0, "reg A after reset");
    check("R1", tune_b_o, 0, "reg B after reset");
    check("R1", test_o, 0, "test reg after reset");
    check("R1", sif_oe_o, 0, "output released after reset");
    check("R1", ctr_reset_o, 0, "counter reset idle");
    check("R1", ifc_restart_o, 0, "restart idle");
    live = 1'b1;

    // R3: test register write
    frame("R3", 0, 2'd0, 21'h0ABCD0, W);
    check("R3", test_o, 21'h0ABCD0, "test reg load");

    // R4 / R7: register A, entering stop gives no pulse
    frame("R4", 0, 2'd2, 21'h161234, W);
    check("R4", tune_a_o, 21'h161234, "reg A load");
    check("R7", got_ctr, 0, "no pulse entering stop");
    frame("R7", 0, 2'd2, 21'h101234, W);
    check("R7", got_ctr, 1, "pulse leaving stop");
    frame("R7", 0, 2'd2, 21'h061234, W);
    frame("R7", 0, 2'd2, 21'h060000, W);
    check("R7", got_ctr, 1, "no pulse stop to stop");
    frame("R7", 0, 2'd2, 21'h040000, W);
    check("R7", got_ctr, 2, "pulse stop to 10");

    // R4: register B
    frame("R4", 0, 2'd3, 21'h000055, W);
    check("R4", tune_b_o, 21'h000055, "reg B load");

    // R5 / R6: status read
    frame("R6", 0, 2'd2, 21'h140000, W);
    stat = 21'h15A5A3;
    frame("R5", 0, 2'd1, '0, W);
    check("R6", tune_a_o, 21'h040000, "IF start flag cleared");
    check("R6", got_ifr, 1, "one restart pulse");

    // R10: wrong bit counts are discarded
    frame("R10", 0, 2'd3, 21'h1FFFFF, W - 1);
    check("R10", tune_b_o, 21'h000055, "short write ignored");
    frame("R10", 0, 2'd3, 21'h1FFFFF, W + 1);
    check("R10", tune_b_o, 21'h000055, "long write ignored");
    frame("R10", 0, 2'd2, 21'h140000, W);
    frame("R10", 0, 2'd1, '0, W - 1);
    check("R10", tune_a_o, 21'h140000, "short read keeps flag");
    check("R10", got_ifr, 1, "short read no pulse");

    // R2: leading junk address edges are pushed out
    frame("R2", 3, 2'd0, 21'h000001, W);
    check("R2", test_o, 21'h000001, "last two edges select mode 0");

    // R4: steering of mode 2 to register B
    frame("R4", 0, 2'd2, 21'h0000AA, W);
    check("R4", tune_b_o, 21'h0000AA, "steered write to B");
    check("R4", tune_a_o, 21'h140000, "A untouched when steered");
    frame("R4", 0, 2'd0, 21'h000000, W);

    // R8: idle output control
    frame("R8", 0, 2'd3, 21'h100000, W);
    set_io(1'b1, 1'b0);
    check("R8", sif_oe_o, 1, "lock drives low");
    check("R8", sif_dat_o, 0, "lock level");
    set_io(1'b0, 1'b1);
    check("R8", sif_oe_o, 0, "no lock released");
    frame("R8", 0, 2'd3, 21'h180000, W);
    check("R8", sif_oe_o, 1, "IF done drives low");
    set_io(1'b1, 1'b0);
    check("R8", sif_oe_o, 0, "IF not done released");
    frame("R8", 0, 2'd3, 21'h080000, W);
    set_io(1'b1, 1'b1);
    check("R8", sif_oe_o, 0, "code 01 released");

    // R9: write frame with lock shown between frames
    frame("R9", 0, 2'd3, 21'h100000, W);
    frame("R9", 0, 2'd0, 21'h012345, W);
    check("R9", test_o, 21'h012345, "write during lock indication");
    check("R9", sif_oe_o, 1, "lock indication back after frame");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule